// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide peripheral that presents a classic printer port, with a virtual printer attached, to a processor bus. Software reaches three registers through a small address bus: a data register, a status register and a control register. Each character that software hands to the printer leaves the block as a one-cycle pulse on a byte stream output. A level interrupt output reports a pending printer event. A byte supplied on a separate reverse-data input can be read back when the port is set to the input direction.

The printer handshake is a state machine with three states. In `HS_READY` the printer is idle and not busy. In `HS_BUSY` it has taken a character and shows busy. In `HS_ACKED` it has dropped the acknowledge line. Four transitions connect the states:

- `T_INIT`: a control write with init low moves any state to `HS_READY`.
- `T_STROBE`: a control write with init, select and strobe all set moves `HS_READY` to `HS_BUSY`.
- `T_ACK_DROP`: a status read while the stored strobe is low moves `HS_BUSY` to `HS_ACKED`.
- `T_RELEASE`: the same status read condition moves `HS_ACKED` back to `HS_READY`.

Software polls the status register to step the machine.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, status reads 0xD9, control reads 0xCC and `irq` is low.
- R2: Only address bits [2:0] are decoded. Offset 0 is data, 1 is status and 2 is control. Offsets 3 to 7 read 0xFF, and upper address bits do not change which register is reached.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. Reading the control register returns that stored value.
- R4: A control write with init (bit 2) low sets status to 0xD8. This value has busy-inverted bit 7, ack bit 6, online bit 4 and error-inverted bit 3 set, with paper-out bit 5 and timeout bit 0 clear.
- R5: A control write with init, select (bit 3) and strobe (bit 0) all set, where the stored strobe was 0, clears status bit 7. In the next cycle it pulses `char_valid` for exactly one cycle, with `char_data` equal to the data register.
- R6: The same write when the stored strobe is already 1 still clears status bit 7, but emits no byte.
- R7: A control write with init and select set and strobe clear raises `irq` in the next cycle if the previously stored control has interrupt enable (bit 4) set. If that bit was clear, `irq` stays unchanged.
- R8: Any status read clears `irq` in the next cycle.
- R9: A status read returns the current status. Then, if status bit 7 is 0 and the stored strobe is 0, it steps the handshake: it clears ack if ack is set, and otherwise sets both ack and bit 7.
- R10: A data read returns the reverse-data byte latched on the previous clock when control direction (bit 5) is 1. Otherwise it returns the last byte written to offset 0.
- R11: Writes to status and to offsets 3 to 7 change no register.
- R12: A control write with select clear leaves the handshake state unchanged and emits no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address; low three bits decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rev_data | input | 8 | Reverse-direction byte from the printer side |
| char_valid | output | 1 | One-cycle pulse per printed character |
| char_data | output | 8 | Character byte, valid with `char_valid` |
| irq | output | 1 | Level interrupt, high while an event is pending |

## Verification
A single status read can clear the pending interrupt and step the handshake in the same cycle. The bench provokes this by enabling interrupts, strobing a character so that the port shows busy, and then writing strobe low to set the pending flag before reading status. It then checks, in the cycle after that one read, both that `irq` has fallen and that the next status value shows ack dropped. A second overlap is a control write that clears busy and emits a byte at once. A per-clock behavioural model also compares both effects over a long run of random accesses.

// File: rtl/prn_pkg.sv
`timescale 1ns/1ps
package prn_pkg;
    localparam int DW    = 8;
    localparam int DEC_W = 3;

    localparam logic [DEC_W-1:0] OFF_DATA = 3'd0;
    localparam logic [DEC_W-1:0] OFF_STAT = 3'd1;
    localparam logic [DEC_W-1:0] OFF_CTRL = 3'd2;

    // status bit positions
    localparam int ST_BUSY_N = 7;
    localparam int ST_ACK    = 6;
    localparam int ST_PAPER  = 5;
    localparam int ST_ONLINE = 4;
    localparam int ST_ERR_N  = 3;
    localparam int ST_TMO    = 0;

    // control bit positions
    localparam int CT_DIR  = 5;
    localparam int CT_IEN  = 4;
    localparam int CT_SEL  = 3;
    localparam int CT_INIT = 2;
    localparam int CT_STB  = 0;

    localparam logic [DW-1:0] CT_FORCED  = 8'hC0;
    localparam logic [DW-1:0] CT_RESET   = 8'hCC;
    localparam logic [DW-1:0] DATA_RESET = 8'hFF;
    localparam logic [DW-1:0] UNMAPPED   = 8'hFF;

    typedef enum logic [1:0] {
        HS_READY = 2'd0,
        HS_BUSY  = 2'd1,
        HS_ACKED = 2'd2
    } hs_state_t;

    typedef struct packed {
        logic data_wr;
        logic ctrl_wr;
        logic stat_rd;
    } acc_t;
endpackage

// File: rtl/prn_bus_decode.sv
`timescale 1ns/1ps
module prn_bus_decode
    import prn_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    output logic [DEC_W-1:0]     off,
    output acc_t                 acc
);
    always_comb begin
        off         = addr[DEC_W-1:0];
        acc.data_wr = sel &&  wr && (off == OFF_DATA);
        acc.ctrl_wr = sel &&  wr && (off == OFF_CTRL);
        acc.stat_rd = sel && !wr && (off == OFF_STAT);
    end
endmodule

// File: rtl/prn_handshake_fsm.sv
`timescale 1ns/1ps
module prn_handshake_fsm
    import prn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] wdata,
    input  logic          stat_rd,
    input  logic          stb_cur,
    output logic [DW-1:0] status
);
    hs_state_t st, st_n;
    logic paper_q, online_q, errn_q, tmo_q;

    // next-state logic
    always_comb begin
        st_n = st;
        if (ctrl_wr) begin
            if (!wdata[CT_INIT])
                st_n = HS_READY;                         // T_INIT
            else if (wdata[CT_SEL] && wdata[CT_STB] && st == HS_READY)
                st_n = HS_BUSY;                          // T_STROBE
        end else if (stat_rd && !stb_cur) begin
            unique case (st)
                HS_BUSY:  st_n = HS_ACKED;               // T_ACK_DROP
                HS_ACKED: st_n = HS_READY;               // T_RELEASE
                default:  st_n = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= HS_READY;
        else        st <= st_n;
    end

    // fixed status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paper_q  <= 1'b0;
            online_q <= 1'b1;
            errn_q   <= 1'b1;
            tmo_q    <= 1'b1;
        end else if (ctrl_wr && !wdata[CT_INIT]) begin
            paper_q  <= 1'b0;
            online_q <= 1'b1;
            errn_q   <= 1'b1;
            tmo_q    <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        status            = '0;
        status[ST_BUSY_N] = (st == HS_READY);
        status[ST_ACK]    = (st != HS_ACKED);
        status[ST_PAPER]  = paper_q;
        status[ST_ONLINE] = online_q;
        status[ST_ERR_N]  = errn_q;
        status[ST_TMO]    = tmo_q;
    end

    assert_init_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[CT_INIT]) |=> (status == 8'hD8));

    assert_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]) |=> !status[ST_BUSY_N]);

    assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && stat_rd && !stb_cur && status[ST_BUSY_N:ST_ACK] == 2'b01)
        |=> (status[ST_BUSY_N:ST_ACK] == 2'b00));
endmodule

// File: rtl/prn_ctrl_unit.sv
`timescale 1ns/1ps
module prn_ctrl_unit
    import prn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          ctrl_wr,
    input  logic          stat_rd,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rev_data,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] dataw_q,
    output logic [DW-1:0] datar_q,
    output logic          char_valid,
    output logic [DW-1:0] char_data,
    output logic          irq
);
    logic [DW-1:0] ctrl_new;
    logic          cycle_ok;
    logic          emit;
    logic          pend_set;

    always_comb begin
        ctrl_new = wdata | CT_FORCED;
        cycle_ok = ctrl_wr && ctrl_new[CT_INIT] && ctrl_new[CT_SEL];
        emit     = cycle_ok && ctrl_new[CT_STB] && !ctrl_q[CT_STB];
        pend_set = cycle_ok && !ctrl_new[CT_STB] && ctrl_q[CT_IEN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= CT_RESET;
            dataw_q    <= DATA_RESET;
            datar_q    <= DATA_RESET;
            char_valid <= 1'b0;
            char_data  <= '0;
            irq        <= 1'b0;
        end else begin
            datar_q    <= rev_data;
            char_valid <= emit;
            if (emit)     char_data <= dataw_q;
            if (data_wr)  dataw_q   <= wdata;
            if (ctrl_wr)  ctrl_q    <= ctrl_new;
            if (pend_set)     irq <= 1'b1;
            else if (stat_rd) irq <= 1'b0;
        end
    end

    assert_emit_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> $past(ctrl_wr && wdata[CT_STB] && wdata[CT_SEL] && wdata[CT_INIT]));

    assert_emit_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl_wr && !wdata[CT_STB]));

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !irq);
endmodule

// File: rtl/prn_port_regs.sv
`timescale 1ns/1ps
module prn_port_regs
    import prn_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        rev_data,
    output logic              char_valid,
    output logic [7:0]        char_data,
    output logic              irq
);
    logic [DEC_W-1:0] off;
    acc_t             acc;
    logic [DW-1:0]    status, ctrl_q, dataw_q, datar_q;

    prn_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .off  (off),
        .acc  (acc)
    );

    prn_ctrl_unit u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (acc.data_wr),
        .ctrl_wr    (acc.ctrl_wr),
        .stat_rd    (acc.stat_rd),
        .wdata      (bus_wdata),
        .rev_data   (rev_data),
        .ctrl_q     (ctrl_q),
        .dataw_q    (dataw_q),
        .datar_q    (datar_q),
        .char_valid (char_valid),
        .char_data  (char_data),
        .irq        (irq)
    );

    prn_handshake_fsm u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (acc.ctrl_wr),
        .wdata   (bus_wdata),
        .stat_rd (acc.stat_rd),
        .stb_cur (ctrl_q[CT_STB]),
        .status  (status)
    );

    // read mux
    always_comb begin
        bus_rdata = UNMAPPED;
        unique case (off)
            OFF_DATA: bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
            OFF_STAT: bus_rdata = status;
            OFF_CTRL: bus_rdata = ctrl_q;
            default:  bus_rdata = UNMAPPED;
        endcase
    end
endmodule

// File: tb/prn_port_regs_bench.sv
`timescale 1ns/1ps
module prn_port_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, rev_data = 8'hFF;
    logic [7:0] bus_rdata, char_data;
    logic       char_valid, irq;

    int vectors = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_dataw, m_datar, m_status, m_ctrl;
    logic       m_pend, m_emit;
    logic [7:0] m_char;
    logic [7:0] char_q[$];

    always #2 clk = ~clk;

    prn_port_regs #(.ADDR_W(4)) u_prn_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rev_data(rev_data), .char_valid(char_valid), .char_data(char_data),
        .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a[2:0])
            3'd0:    return m_ctrl[5] ? m_datar : m_dataw;
            3'd1:    return m_status;
            3'd2:    return m_ctrl;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic m_reset();
        m_dataw = 8'hFF; m_datar = 8'hFF; m_status = 8'hD9;
        m_ctrl = 8'hCC; m_pend = 0; m_emit = 0; m_char = 0;
    endtask

    task automatic m_step(input logic s, input logic w, input logic [3:0] a, input logic [7:0] d);
        logic [7:0] v;
        m_emit = 0;
        if (s && w && a[2:0] == 3'd0) m_dataw = d;
        if (s && w && a[2:0] == 3'd2) begin
            v = d | 8'hC0;
            if (!v[2]) m_status = 8'hD8;
            else if (v[3]) begin
                if (v[0]) begin
                    m_status[7] = 1'b0;
                    if (!m_ctrl[0]) begin m_emit = 1; m_char = m_dataw; char_q.push_back(m_dataw); end
                end else if (m_ctrl[4]) m_pend = 1;
            end
            m_ctrl = v;
        end
        if (s && !w && a[2:0] == 3'd1) begin
            m_pend = 0;
            if (!m_status[7] && !m_ctrl[0]) begin
                if (m_status[6]) m_status[6] = 1'b0;
                else m_status = m_status | 8'hC0;
            end
        end
        m_datar = rev_data;
    endtask

    // one bus cycle; called just after a falling edge
    task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                       input logic [7:0] d, input string req);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        if (s && !w) check(req, bus_rdata, m_read(a));
        @(posedge clk);
        m_step(s, w, a, d);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        check({req, " irq"}, {7'd0, irq}, {7'd0, m_pend});
        check({req, " char_valid"}, {7'd0, char_valid}, {7'd0, m_emit});
        if (m_emit) begin
            check({req, " char_data"}, char_data, m_char);
            void'(char_q.pop_front());
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
        cyc(1, 1, a, d, req);
    endtask
    task automatic rd(input logic [3:0] a, input string req);
        cyc(1, 0, a, 8'h00, req);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(4'd0, "R1 data"); rd(4'd1, "R1 status"); rd(4'd2, "R1 control");
        check("R1 status value", m_status, 8'hD9);
        // R2 unmapped and alias
        for (int i = 3; i < 8; i++) rd(4'(i), "R2 unmapped");
        wr(4'd0, 8'h41, "R2 data write");
        rd(4'd8, "R2 alias data");
        rd(4'd10, "R2 alias control");
        // R3 control storage, R5 strobe rising emits
        wr(4'd2, 8'h0D, "R5 strobe rise");
        rd(4'd2, "R3 control readback");
        rd(4'd1, "R5 busy cleared");
        // R6 strobe already high
        wr(4'd0, 8'h42, "R6 data");
        wr(4'd2, 8'h0D, "R6 strobe held");
        // R9 handshake: strobe low then poll
        wr(4'd2, 8'h0C, "R9 strobe low");
        rd(4'd1, "R9 poll busy");
        rd(4'd1, "R9 poll acked");
        rd(4'd1, "R9 poll ready");
        // R7 interrupt enable needs previous control
        wr(4'd2, 8'h1C, "R7 enable first");
        wr(4'd2, 8'h1C, "R7 enable pend");
        wr(4'd0, 8'h55, "R7 data write keeps irq");
        rd(4'd1, "R8 status clears irq");
        // R10 direction
        rev_data = 8'h5A;
        wr(4'd2, 8'h2C, "R10 dir in");
        rd(4'd0, "R10 reverse data");
        rev_data = 8'hA3;
        rd(4'd0, "R10 reverse data next");
        wr(4'd2, 8'h0C, "R10 dir out");
        rd(4'd0, "R10 written data");
        // R4 init
        wr(4'd2, 8'h08, "R4 init low");
        rd(4'd1, "R4 status");
        // R11 ignored writes
        wr(4'd1, 8'h00, "R11 status write");
        wr(4'd5, 8'h00, "R11 offset5 write");
        rd(4'd1, "R11 status kept");
        rd(4'd0, "R11 data kept");
        rd(4'd2, "R11 control kept");
        // R12 select low
        wr(4'd0, 8'h33, "R12 data");
        wr(4'd2, 8'h05, "R12 strobe no select");
        rd(4'd1, "R12 status kept");
        // same-cycle: irq clear and handshake step on one status read
        wr(4'd2, 8'h1C, "R8 enable");
        wr(4'd2, 8'h1D, "R5 strobe with enable");
        wr(4'd2, 8'h1C, "R7 pend with busy");
        check("R7 irq raised", {7'd0, irq}, 8'h01);
        rd(4'd1, "R8 read clears and steps");
        check("R8 irq low", {7'd0, irq}, 8'h00);
        rd(4'd1, "R9 ack dropped");
        // random traffic
        for (int n = 0; n < 600; n++) begin
            rev_data = 8'($urandom);
            cyc(($urandom % 4) != 0, $urandom % 2, 4'($urandom), 8'($urandom), "R2,R9 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule